// File: doc/BRIEF.md
# Prioritized Interrupt Aggregator with Idle Handshake

This block collects a vector of level-sensitive interrupt lines and drives a single interrupt output toward a host processor. Each line is resynchronized to the functional clock and becomes visible in a status register. The output rises as soon as any unmasked line is seen, and no priority resolution has to finish first. While the output is high, a scan of fixed length runs in the background. The scan finds the winning line, which is the lowest index that is active when the scan ends. Its number is then loaded into the source register.

The host reaches four registers over a small register bus. A read of the source register is held off with a wait signal until the scan finishes. After servicing, the host writes a one to the acknowledge bit of the control register. This drops the output and re-arms the controller, so any line still active raises it again. A separate request/acknowledge pair lets the host ask whether the functional clock may be stopped. The control register selects one of two policies: a forced policy that always grants, and a smart policy that waits until nothing is pending.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, irq_o and idle_ack_o are low, the source register (address 1) reads all ones, the mask register (address 3) reads 0 and the control register (address 2) reads 0.
- R2: When an unmasked line rises, irq_o goes high after the third rising clock edge following the change, with no dependence on priority resolution.
- R3: A line whose bit is 1 in the mask register still appears in the status register (address 0), but it never raises irq_o.
- R4: A read of the source register keeps bus_ready_o low until SCAN_CYC rising edges after the edge that raised irq_o. Reads of other addresses and all writes complete in the cycle they are issued.
- R5: When the scan ends, the source register holds the lowest index among unmasked active lines, whatever the number of active lines. If none is active, it holds all ones (15 for the default 4-bit field).
- R6: Reading the source register changes neither the status register nor the stored source number while the line is still asserted.
- R7: Writing 1 to control bit 0 drops irq_o at the next edge. Bit 0 always reads back 0.
- R8: A line that becomes active while irq_o is high and unacknowledged only shows in the status register. irq_o stays high, and it rises again one edge after the acknowledge write, with a new scan that reports that line.
- R9: Control bit 1 set to 0 selects the forced policy. idle_ack_o follows idle_req_i one edge later, whatever is pending.
- R10: Control bit 1 set to 1 selects the smart policy. idle_ack_o stays low while any unmasked line is active or irq_o is high, including when the request arrives in the same cycle as a newly detected line.
- R11: While idle_ack_o is high and irq_o is low, irq_o stays low. Lowering idle_req_i drops idle_ack_o at the next edge, after which a pending line raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level-sensitive interrupt lines |
| irq_o | output | 1 | Interrupt output to the host |
| bus_req_i | input | 1 | Register access request, held until ready |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 2 | 0 status, 1 source, 2 control, 3 mask |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid when ready |
| bus_ready_o | output | 1 | Access completes on the next edge when high |
| idle_req_i | input | 1 | Host asks to stop the functional clock |
| idle_ack_o | output | 1 | Clock may be stopped |

## Verification
The hardest collision is an idle request under the smart policy that arrives in the same cycle as a line that has just cleared the resynchronizer. The interrupt start and the idle grant are then decided at the same clock edge. The bench raises the line, waits two cycles, and raises the request so that both are evaluated together. It then expects irq_o high and idle_ack_o held low for several cycles, and the stalled source read must name that line. A second overlap is an acknowledge write while another line is still active: the output must drop for exactly one cycle and then rise again.

// File: rtl/irq_aggregator_pkg.sv
package irq_aggregator_pkg;
  localparam logic [1:0] REG_STAT = 2'd0;
  localparam logic [1:0] REG_SRC  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_MASK = 2'd3;
  localparam int CTRL_AGR_BIT  = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam logic IDLE_FORCE = 1'b0;
  localparam logic IDLE_SMART = 1'b1;
endpackage

// File: rtl/irq_aggregator_sync.sv
module irq_aggregator_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_aggregator_scan.sv
module irq_aggregator_scan #(
  parameter int N_SRC    = 8,
  parameter int SCAN_CYC = 10,
  parameter int SRC_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [N_SRC-1:0] pend_i,
  output logic             busy_o,
  output logic [SRC_W-1:0] src_o
);
  localparam int CW = (SCAN_CYC > 1) ? $clog2(SCAN_CYC) : 1;

  logic [CW-1:0]    cnt_q;
  logic             busy_q;
  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] win;

  // lowest index wins; all ones when nothing is active
  always_comb begin
    win = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) win = SRC_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      src_q  <= '1;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(SCAN_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        src_q  <= win;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign src_o  = src_q;
endmodule

// File: rtl/irq_aggregator_idle.sv
module irq_aggregator_idle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic smart_i,
  input  logic active_i,
  output logic ack_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_i && (!smart_i || !active_i);
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_aggregator_pkg::*;
#(
  parameter int N_SRC       = 8,
  parameter int SCAN_CYC    = 10,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  output logic             irq_o,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             bus_ready_o,
  input  logic             idle_req_i,
  output logic             idle_ack_o
);
  localparam int SRC_W = $clog2(N_SRC + 1);

  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] pend;
  logic             mode_q;
  logic             irq_q;
  logic             scan_busy;
  logic [SRC_W-1:0] src_num;
  logic             src_rd;
  logic             wr_en;
  logic             agr_wr;
  logic             start;

  irq_aggregator_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (status)
  );

  assign pend   = status & ~mask_q;
  assign src_rd = bus_req_i && !bus_we_i && (bus_addr_i == REG_SRC);
  assign bus_ready_o = bus_req_i && !(src_rd && scan_busy);
  assign wr_en  = bus_ready_o && bus_we_i;
  assign agr_wr = wr_en && (bus_addr_i == REG_CTRL) && bus_wdata_i[CTRL_AGR_BIT];
  assign start  = !irq_q && (|pend) && !idle_ack_o && !agr_wr;

  irq_aggregator_scan #(.N_SRC(N_SRC), .SCAN_CYC(SCAN_CYC), .SRC_W(SRC_W)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .abort_i(agr_wr),
    .pend_i (pend),
    .busy_o (scan_busy),
    .src_o  (src_num)
  );

  irq_aggregator_idle u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (idle_req_i),
    .smart_i (mode_q == IDLE_SMART),
    .active_i((|pend) || irq_q),
    .ack_o   (idle_ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      mask_q <= '0;
      mode_q <= IDLE_FORCE;
    end else begin
      if (agr_wr)     irq_q <= 1'b0;
      else if (start) irq_q <= 1'b1;
      if (wr_en && bus_addr_i == REG_MASK) mask_q <= bus_wdata_i[N_SRC-1:0];
      if (wr_en && bus_addr_i == REG_CTRL) mode_q <= bus_wdata_i[CTRL_MODE_BIT];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_STAT: bus_rdata_o[N_SRC-1:0]     = status;
      REG_SRC:  bus_rdata_o[SRC_W-1:0]     = src_num;
      REG_CTRL: bus_rdata_o[CTRL_MODE_BIT] = mode_q;
      default:  bus_rdata_o[N_SRC-1:0]     = mask_q;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_SRC = 8,
  parameter int SRC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             idle_ack_o,
  input logic             idle_req_i,
  input logic             bus_req_i,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic             bus_ready_o,
  input logic [N_SRC-1:0] pend,
  input logic             scan_busy,
  input logic             agr_wr,
  input logic             mode_q,
  input logic [SRC_W-1:0] src_num
);
  AST_IRQ_DETECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && (|pend) && !idle_ack_o && !agr_wr) |=> irq_o); // R2
  AST_SRC_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == 2'd1 && scan_busy) |-> !bus_ready_o); // R4
  AST_SRC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_busy |-> (src_num == '1 || int'(src_num) < N_SRC)); // R5
  AST_AGR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agr_wr |=> !irq_o); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !agr_wr) |=> irq_o); // R8
  AST_FORCE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_req_i && !mode_q) |=> idle_ack_o); // R9
  AST_SMART_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_req_i && mode_q && ((|pend) || irq_o)) |=> !idle_ack_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ack_o && !irq_o) |=> !irq_o); // R11
  AST_IDLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_req_i |=> !idle_ack_o); // R11
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .idle_ack_o (idle_ack_o),
  .idle_req_i (idle_req_i),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_ready_o(bus_ready_o),
  .pend       (pend),
  .scan_busy  (scan_busy),
  .agr_wr     (agr_wr),
  .mode_q     (mode_q),
  .src_num    (src_num)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  localparam int N = 8;
  localparam int SCAN = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic irq;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ready;
  logic idle_req = 1'b0;
  logic idle_ack;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  irq_aggregator #(.N_SRC(N), .SCAN_CYC(SCAN), .SYNC_STAGES(2), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .irq_o(irq),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_ready_o(ready),
    .idle_req_i(idle_req), .idle_ack_o(idle_ack)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads as they complete
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (req && !we && ready) begin
        if (sb_q.size() == 0) begin
          chk("scoreboard empty", 1, 0);
        end else begin
          it = sb_q.pop_front();
          chk(it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string tag,
                    input int exp_stall);
    int stalls;
    item_t it;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    stalls = 0;
    #2;
    while (!ready) begin
      stalls++;
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    req = 1'b0;
    if (exp_stall >= 0) chk({tag, " stall"}, stalls, exp_stall);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    #2;
    chk("R1 irq reset", irq, 0);
    chk("R1 ack reset", idle_ack, 0);
    rd(2'd1, 32'hF, "R1 src reset", 0);
    rd(2'd3, 0, "R1 mask reset", 0);
    rd(2'd2, 0, "R1 ctrl reset", 0);

    // R2 latency, R4 stall, R5 priority
    @(negedge clk); src = 8'h2C; #2;
    chk("R2 irq edge0", irq, 0);
    repeat (2) begin @(negedge clk); #2; chk("R2 irq early", irq, 0); end
    @(negedge clk); #2;
    chk("R2 irq third edge", irq, 1);
    rd(2'd1, 2, "R5 src lowest of three R4", SCAN - 1);
    rd(2'd0, 32'h2C, "R6 status after src read", 0);

    // R8 new line while held
    @(negedge clk); src = 8'h2D;
    cyc(4); #2;
    chk("R8 irq held", irq, 1);
    rd(2'd0, 32'h2D, "R8 status shows new line", 0);
    rd(2'd1, 2, "R6 src unchanged", 0);

    // R7 acknowledge, R8 re-assert
    wr(2'd2, 1); #2;
    chk("R7 irq drop", irq, 0);
    @(negedge clk); #2;
    chk("R8 irq reassert", irq, 1);
    rd(2'd2, 0, "R7 ack bit reads 0", 0);
    rd(2'd1, 0, "R8 rescan reports line 0", -1);

    // R3 masking
    @(negedge clk); src = '0;
    cyc(3);
    wr(2'd2, 1);
    cyc(3); #2;
    chk("R7 irq stays low", irq, 0);
    wr(2'd3, 32'h10);
    @(negedge clk); src = 8'h10;
    cyc(6); #2;
    chk("R3 masked no irq", irq, 0);
    rd(2'd0, 32'h10, "R3 masked in status", 0);
    @(negedge clk); src = 8'h90;
    cyc(4); #2;
    chk("R3 unmasked irq", irq, 1);
    rd(2'd1, 7, "R5 masked line skipped", -1);

    // R5 empty at scan end
    @(negedge clk); src = '0;
    cyc(3);
    wr(2'd2, 1);
    cyc(2);
    @(negedge clk); src = 8'h80;
    @(negedge clk); src = '0;
    cyc(3); #2;
    chk("R5 pulse raises irq", irq, 1);
    rd(2'd1, 32'hF, "R5 none at scan end", -1);

    // R9 forced idle, R11
    wr(2'd2, 1);
    cyc(3); #2;
    chk("R7 irq low before idle", irq, 0);
    @(negedge clk); idle_req = 1'b1; #2;
    chk("R9 ack not yet", idle_ack, 0);
    @(negedge clk); #2;
    chk("R9 ack one edge", idle_ack, 1);
    @(negedge clk); src = 8'h01;
    cyc(6); #2;
    chk("R11 no irq while acked", irq, 0);
    chk("R9 forced ack holds", idle_ack, 1);
    @(negedge clk); idle_req = 1'b0; #2;
    chk("R11 ack before edge", idle_ack, 1);
    @(negedge clk); #2;
    chk("R11 ack drops", idle_ack, 0);
    @(negedge clk); #2;
    chk("R11 irq resumes", irq, 1);

    // R10 smart idle
    wr(2'd2, 2);
    rd(2'd2, 2, "R10 mode bit", 0);
    @(negedge clk); idle_req = 1'b1;
    cyc(5); #2;
    chk("R10 ack withheld pending", idle_ack, 0);
    @(negedge clk); src = '0;
    cyc(3); #2;
    chk("R10 ack withheld irq", idle_ack, 0);
    wr(2'd2, 3);
    cyc(3); #2;
    chk("R10 irq cleared", irq, 0);
    chk("R10 ack granted", idle_ack, 1);
    @(negedge clk); idle_req = 1'b0;
    cyc(2);

    // R10 request and detection in the same cycle
    @(negedge clk); src = 8'h04;
    @(negedge clk);
    @(negedge clk); idle_req = 1'b1; #2;
    chk("R10 same cycle ack", idle_ack, 0);
    @(negedge clk); #2;
    chk("R10 same cycle irq", irq, 1);
    chk("R10 same cycle no ack", idle_ack, 0);
    cyc(4); #2;
    chk("R10 ack still withheld", idle_ack, 0);
    rd(2'd1, 2, "R10 src after collision", -1);
    @(negedge clk); idle_req = 1'b0; src = '0;
    cyc(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule